// File: doc/BRIEF.md
# Host-Driven Remote Transfer Engine

This block moves data between a host data port and a byte-wide local packet memory. Software loads a 16-bit memory pointer and a 16-bit byte count through a small register port, then writes a 3-bit command. The engine then serves host data-port accesses one at a time. Each read access fetches from memory at the pointer. Each write access stores to memory at the pointer. After every access the pointer moves forward and the count moves down.

A configuration register selects the transfer width and the lane order. In byte mode each access moves one byte. In word mode each access moves a 16-bit word as two consecutive memory bytes, and the lane order decides which of those bytes appears in the low half of the data port. When the count runs out, the engine raises a completion flag and stops serving accesses. An abort command stops it at any time. After an abort the pointer and count keep whatever values they had reached.

Top module: `rdma_engine`

## Requirements
- R1: After reset the pointer, count, configuration and status all read as zero.
- R2: Register map on `reg_addr`. Addresses 0 and 1 hold the pointer low and high bytes, and addresses 2 and 3 hold the count low and high bytes; all four are written and read back directly. Address 5 is the configuration register: bit 0 selects word mode, bit 1 selects the big-endian lane order, and the other bits read as 0.
- R3: A write to address 4 issues a command from bits [2:0]. Code 001 starts a read transfer, 010 starts a write transfer, and 011 runs as a read transfer. Reading address 4 returns status: bit 0 is done, bit 1 is busy, and bit 2 is the direction of the last started transfer (1 for write).
- R4: Command code 000 is ignored. The engine stays idle, the status does not change, and data-port accesses are not served.
- R5: In byte mode each served access moves one byte at the pointer, using lane [7:0] of the data port (upper lane reads as 0). The pointer then rises by 1 and the count falls by 1.
- R6: In word mode each served access moves the bytes at the pointer and at pointer+1. The pointer then rises by 2 and the count falls by 2. A remaining count of 1 goes to 0.
- R7: In word mode with lane order 0, the byte at the pointer maps to data lane [7:0]. With lane order 1, it maps to lane [15:8].
- R8: When the count reaches zero, done is set and busy clears. A start command clears done. A start command issued with a zero count sets done at once and leaves busy clear.
- R9: Any command code with bit 2 set stops the transfer at once. Done is not set, and the pointer and count keep their advanced values.
- R10: Each served access is acknowledged by exactly one cycle of `dp_ready`. An access is not acknowledged, and memory is not touched, if the engine is idle or if the access direction does not match the running transfer.
- R11: The memory port performs at most one byte operation per cycle and never reads and writes in the same cycle. Read data is expected one cycle after `mem_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| dp_rd | input | 1 | Host data-port read request, held until acknowledged |
| dp_wr | input | 1 | Host data-port write request, held until acknowledged |
| dp_wdata | input | 16 | Host write data |
| dp_rdata | output | 16 | Host read data, valid while `dp_ready` is high |
| dp_ready | output | 1 | One-cycle access acknowledge |
| mem_addr | output | 16 | Local memory byte address |
| mem_rd | output | 1 | Local memory read strobe |
| mem_wr | output | 1 | Local memory write strobe |
| mem_wdata | output | 8 | Local memory write data |
| mem_rdata | input | 8 | Local memory read data, one cycle after `mem_rd` |

## Verification
The assertions assume that the host keeps a data-port request steady until it sees the acknowledge, and that it drops the request in the same cycle the acknowledge appears. They also assume that the host never raises both request lines together and never rewrites the pointer, count or configuration while a transfer runs. The bench drives every request from one task that asserts exactly one line and releases it on the acknowledge or on a timeout. Register writes are issued only while the engine is idle, or as commands. The memory model in the bench answers reads with a one-cycle latency, as R11 expects.

// File: rtl/rdma_engine.sv
module rdma_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        dp_rd,
  input  logic        dp_wr,
  input  logic [15:0] dp_wdata,
  output logic [15:0] dp_rdata,
  output logic        dp_ready,
  output logic [15:0] mem_addr,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata
);
  typedef enum logic [2:0] {S_WAIT, S_LO, S_HI, S_FIN, S_ACK} step_t;

  step_t       st;
  logic [15:0] ptr, cnt;
  logic        word, bigend, busy, done, dir;
  logic [7:0]  first_b;

  logic        cmd_wr, cmd_abort, cmd_start, req, mem_op;
  logic [15:0] stride, cnt_nx, rd_word;

  assign cmd_wr    = reg_we && reg_addr == 3'd4;
  assign cmd_abort = cmd_wr && reg_wdata[2];
  assign cmd_start = cmd_wr && !reg_wdata[2] && reg_wdata[1:0] != 2'b00;
  assign req       = busy && (dir ? dp_wr : dp_rd);

  assign stride = word ? 16'd2 : 16'd1;
  assign cnt_nx = (cnt > stride) ? cnt - stride : 16'd0;

  assign mem_op    = busy && (st == S_LO || st == S_HI);
  assign mem_rd    = mem_op && !dir;
  assign mem_wr    = mem_op && dir;
  assign mem_addr  = (st == S_HI) ? ptr + 16'd1 : ptr;
  assign mem_wdata = ((st == S_HI) ^ bigend) && word ? dp_wdata[15:8] : dp_wdata[7:0];

  assign rd_word = !word  ? {8'h00, mem_rdata} :
                   bigend ? {first_b, mem_rdata} : {mem_rdata, first_b};

  assign dp_ready = (st == S_ACK);

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = ptr[7:0];
      3'd1:    reg_rdata = ptr[15:8];
      3'd2:    reg_rdata = cnt[7:0];
      3'd3:    reg_rdata = cnt[15:8];
      3'd4:    reg_rdata = {5'b0, dir, busy, done};
      3'd5:    reg_rdata = {6'b0, bigend, word};
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_WAIT;
      ptr <= '0;
      cnt <= '0;
      word <= 1'b0;
      bigend <= 1'b0;
      busy <= 1'b0;
      done <= 1'b0;
      dir <= 1'b0;
      first_b <= '0;
      dp_rdata <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          3'd0: ptr[7:0]  <= reg_wdata;
          3'd1: ptr[15:8] <= reg_wdata;
          3'd2: cnt[7:0]  <= reg_wdata;
          3'd3: cnt[15:8] <= reg_wdata;
          3'd5: {bigend, word} <= reg_wdata[1:0];
          default: ;
        endcase
      end

      case (st)
        S_WAIT: if (req) st <= S_LO;
        S_LO:   st <= word ? S_HI : S_FIN;
        S_HI:   begin first_b <= mem_rdata; st <= S_FIN; end
        S_FIN: begin
          dp_rdata <= dir ? 16'h0000 : rd_word;
          ptr <= ptr + stride;
          cnt <= cnt_nx;
          if (cnt_nx == 16'd0) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
          st <= S_ACK;
        end
        default: st <= S_WAIT;
      endcase

      if (cmd_start) begin
        dir  <= reg_wdata[1:0] == 2'b10;
        st   <= S_WAIT;
        busy <= (cnt != 16'd0);
        done <= (cnt == 16'd0);
      end
      if (cmd_abort) begin
        busy <= 1'b0;
        st   <= S_WAIT;
      end
    end
  end
endmodule

module rdma_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [2:0]  reg_addr,
  input logic [7:0]  reg_wdata,
  input logic        dp_ready,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic        busy,
  input logic        done,
  input logic [15:0] cnt
);
  a_r10_ready_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    dp_ready |=> !dp_ready);

  a_r11_no_rd_wr_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r10_no_mem_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> busy);

  a_r9_abort_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd4 && reg_wdata[2]) |=> (!busy && !dp_ready));

  a_r8_done_only_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> cnt == 16'd0);

  a_r4_illegal_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd4 && reg_wdata[2:0] == 3'b000 && !busy) |=> !busy);
endmodule

bind rdma_engine rdma_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .dp_ready(dp_ready), .mem_rd(mem_rd),
  .mem_wr(mem_wr), .busy(busy), .done(done), .cnt(cnt)
);

// File: tb/test_rdma_engine.sv
module test_rdma_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0, reg_rdata;
  logic        dp_rd = 1'b0, dp_wr = 1'b0, dp_ready;
  logic [15:0] dp_wdata = '0, dp_rdata;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata, mem_rdata = '0;

  logic [7:0]  mem [256];
  int          mem_ops = 0;
  int          n_chk = 0, n_bad = 0;
  bit          finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdma_engine i_rdma_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dp_rd(dp_rd), .dp_wr(dp_wr),
    .dp_wdata(dp_wdata), .dp_rdata(dp_rdata), .dp_ready(dp_ready),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_rd || mem_wr) mem_ops <= mem_ops + 1;
  end

  // {cfg[1:0], addr[7:0], expected read data[15:0]}; memory byte = addr ^ 8'h5A
  localparam logic [25:0] VEC [6] = '{
    {2'd0, 8'h10, 16'h004A},
    {2'd2, 8'h20, 16'h007A},
    {2'd1, 8'h10, 16'h4B4A},
    {2'd3, 8'h10, 16'h4A4B},
    {2'd1, 8'h33, 16'h6E69},
    {2'd3, 8'h20, 16'h7A7B}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic access(input bit wr, input logic [15:0] wd, output logic [15:0] rd, output bit acked);
    @(negedge clk);
    dp_rd = !wr; dp_wr = wr; dp_wdata = wd; acked = 0; rd = '0;
    for (int i = 0; i < 12 && !acked; i++) begin
      @(negedge clk);
      if (dp_ready) begin acked = 1; rd = dp_rdata; end
    end
    dp_rd = 1'b0; dp_wr = 1'b0;
  endtask

  task automatic setup(input logic [7:0] cfg, input logic [15:0] a, input logic [15:0] n);
    wreg(3'd5, cfg);
    wreg(3'd0, a[7:0]);  wreg(3'd1, a[15:8]);
    wreg(3'd2, n[7:0]);  wreg(3'd3, n[15:8]);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  r;
    logic [15:0] d;
    bit          ack;
    int          ops0;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rreg(3'(a), r); chk("R1 reset register", {8'h0, r}, 16'h0000);
    end

    // R2 register readback
    setup(8'hFF, 16'hA53C, 16'h017E);
    rreg(3'd0, r); chk("R2 pointer low", {8'h0, r}, 16'h003C);
    rreg(3'd1, r); chk("R2 pointer high", {8'h0, r}, 16'h00A5);
    rreg(3'd2, r); chk("R2 count low", {8'h0, r}, 16'h007E);
    rreg(3'd3, r); chk("R2 count high", {8'h0, r}, 16'h0001);
    rreg(3'd5, r); chk("R2 config unused bits zero", {8'h0, r}, 16'h0003);

    // R5 R6 R7 vector table: one read access per vector
    foreach (VEC[k]) begin
      logic [15:0] st;
      st = VEC[k][24] ? 16'd2 : 16'd1;
      setup({6'b0, VEC[k][25:24]}, {8'h00, VEC[k][23:16]}, 16'd8);
      wreg(3'd4, 8'h01);
      access(1'b0, 16'h0, d, ack);
      chk("R10 read acknowledged", {15'b0, ack}, 16'h0001);
      chk("R5/R6/R7 read data", d, VEC[k][15:0]);
      rreg(3'd0, r); chk("R5/R6 pointer step", {8'h0, r}, VEC[k][23:16] + st);
      rreg(3'd2, r); chk("R5/R6 count step", {8'h0, r}, 16'd8 - st);
      wreg(3'd4, 8'h04);
    end

    // R4 illegal code ignored
    wreg(3'd4, 8'h00);
    rreg(3'd4, r); chk("R4 status unchanged", {8'h0, r}, 16'h0000);
    ops0 = mem_ops;
    access(1'b0, 16'h0, d, ack);
    chk("R4 access not served", {15'b0, ack}, 16'h0000);
    chk("R4 memory untouched", 16'(mem_ops - ops0), 16'h0000);

    // R3 R7 R8 R11 word big-endian write transfer
    setup(8'h03, 16'h0080, 16'd4);
    wreg(3'd4, 8'h02);
    rreg(3'd4, r); chk("R3 write transfer busy", {8'h0, r}, 16'h0006);
    access(1'b1, 16'h1234, d, ack);
    access(1'b1, 16'hABCD, d, ack);
    chk("R10 write acknowledged", {15'b0, ack}, 16'h0001);
    chk("R7 mem 80", {8'h0, mem[8'h80]}, 16'h0012);
    chk("R7 mem 81", {8'h0, mem[8'h81]}, 16'h0034);
    chk("R7 mem 82", {8'h0, mem[8'h82]}, 16'h00AB);
    chk("R7 mem 83", {8'h0, mem[8'h83]}, 16'h00CD);
    rreg(3'd4, r); chk("R8 done after count exhausted", {8'h0, r}, 16'h0005);
    ops0 = mem_ops;
    access(1'b1, 16'h5555, d, ack);
    chk("R8 no access after done", {15'b0, ack}, 16'h0000);
    chk("R11 memory untouched after done", 16'(mem_ops - ops0), 16'h0000);

    // R6 odd count in word mode
    setup(8'h01, 16'h0040, 16'd3);
    wreg(3'd4, 8'h01);
    rreg(3'd4, r); chk("R8 start clears done", {8'h0, r}, 16'h0002);
    access(1'b0, 16'h0, d, ack);
    chk("R6 first word", d, 16'h1B1A);
    rreg(3'd2, r); chk("R6 count after first", {8'h0, r}, 16'h0001);
    access(1'b0, 16'h0, d, ack);
    chk("R6 second word", d, 16'h1918);
    rreg(3'd2, r); chk("R6 count clamps to zero", {8'h0, r}, 16'h0000);
    rreg(3'd0, r); chk("R6 pointer after two words", {8'h0, r}, 16'h0044);
    rreg(3'd4, r); chk("R8 done at zero", {8'h0, r}, 16'h0001);

    // R8 zero-count start
    setup(8'h00, 16'h0050, 16'd0);
    wreg(3'd4, 8'h02);
    rreg(3'd4, r); chk("R8 zero count completes at once", {8'h0, r}, 16'h0005);

    // R3 R9 R10 send code reads, wrong direction, abort
    setup(8'h00, 16'h0010, 16'd6);
    wreg(3'd4, 8'h03);
    rreg(3'd4, r); chk("R3 code 011 runs as read", {8'h0, r}, 16'h0002);
    access(1'b0, 16'h0, d, ack);
    chk("R3 send-code data 0", d, 16'h004A);
    ops0 = mem_ops;
    access(1'b1, 16'hEEEE, d, ack);
    chk("R10 wrong direction ignored", {15'b0, ack}, 16'h0000);
    chk("R10 wrong direction no memory op", 16'(mem_ops - ops0), 16'h0000);
    chk("R10 memory kept", {8'h0, mem[8'h11]}, 16'h004B);
    access(1'b0, 16'h0, d, ack);
    chk("R3 send-code data 1", d, 16'h004B);
    wreg(3'd4, 8'h07);
    rreg(3'd4, r); chk("R9 abort stops without done", {8'h0, r}, 16'h0000);
    rreg(3'd0, r); chk("R9 pointer not restored", {8'h0, r}, 16'h0012);
    rreg(3'd2, r); chk("R9 count kept", {8'h0, r}, 16'h0004);
    access(1'b0, 16'h0, d, ack);
    chk("R9 no access after abort", {15'b0, ack}, 16'h0000);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule